// File: doc/BRIEF.md
# Nonrestoring Mantissa Divider with Exponent Correction

This unit assists a fixed-point processor with single-precision division. Software works out the quotient sign, rejects zero and special operands, and subtracts the biased exponents. It then writes three values into the unit through a 16-bit write port: the 24-bit dividend mantissa, the 24-bit divisor mantissa (each as a low and a high word), and the preliminary exponent.

A start pulse launches a nonrestoring division that produces one quotient bit per clock. The remainder is never restored inside the loop. It is corrected once, after the last bit, to form the sticky information. The 26-bit quotient is then normalized and rounded, either to nearest-even or toward zero. The exponent is moved down when normalization shifts left and up when rounding carries out of the mantissa. Software reads the final mantissa and exponent back as 16-bit words. They stay valid until the next operation completes.

Top module: `nrdiv_assist`

## Requirements
- R1: After reset, busy and done are low and rd_data reads zero for every rd_sel code.
- R2: Write map on wr_sel: 0 takes dividend mantissa bits 15:0; 1 takes dividend bits 23:16 from wr_data[7:0], and wr_data[15:8] is ignored; 2 and 3 do the same for the divisor; 4 takes the 16-bit exponent; codes 5 to 7 change nothing. Read map on rd_sel: 0 gives result mantissa bits 15:0, 1 gives bits 23:16 zero-extended, 2 gives the result exponent, 3 gives zero.
- R3: A start sampled while busy is low is accepted. Busy is high from the next cycle. Done is high for exactly one cycle, visible 27 clock edges after the accepting edge. Busy is low while done is high.
- R4: With both mantissas having bit 23 set, the result mantissa has bit 23 set. It equals the quotient dividend/divisor truncated to 24 significant bits, before the rounding increment.
- R5: The result exponent is the written exponent when dividend >= divisor. It is one less when dividend < divisor, in 16-bit two's complement wrap-around. It is one more if rounding carries out of the mantissa.
- R6: With round_tz low, the mantissa is incremented when the guard bit is set and either the sticky bit or the mantissa LSB is set. The sticky bit is set by any lower quotient bit or a nonzero final remainder.
- R7: With round_tz high, the mantissa is the truncated quotient and is never incremented.
- R8: A start while busy is ignored. Register writes during a run do not change the running result, but they are used by the next accepted start.
- R9: Result words hold their values between completions. Operand writes without a start leave rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 16 | Register write data |
| start | input | 1 | Launch request, accepted when idle |
| round_tz | input | 1 | 1 = round toward zero, 0 = nearest-even; sampled at start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_sel | input | 2 | Result word select |
| rd_data | output | 16 | Selected result word |

## Verification
The hardest situation to reach from the ports is a second start, and new operand writes, arriving while the loop is mid-run. Both must leave the running quotient alone, and the written values must still reach the next run. The stimulus issues them a few cycles into an operation and then starts again without rewriting anything. Quotients just below one are also built on purpose, with the dividend a few units under the divisor. That exercises the normalization shift together with guard and sticky bits that are set. The exponent 0 case checks the wrap on decrement.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_DVD_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DVD_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DVS_LO = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DVS_HI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_EXP    = 3'd4;

  localparam int RSEL_W = 2;
  localparam logic [RSEL_W-1:0] RD_MANT_LO = 2'd0;
  localparam logic [RSEL_W-1:0] RD_MANT_HI = 2'd1;
  localparam logic [RSEL_W-1:0] RD_EXP     = 2'd2;

  typedef enum logic {CTL_IDLE = 1'b0, CTL_RUN = 1'b1} ctl_state_e;
  typedef enum logic {RND_NEAR_EVEN = 1'b0, RND_TO_ZERO = 1'b1} rnd_mode_e;
endpackage

// File: rtl/nrdiv_regs.sv
module nrdiv_regs
  import nrdiv_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [MANT_W-1:0] dvd_mant,
  output logic [MANT_W-1:0] dvs_mant,
  output logic [WORD_W-1:0] exp_word
);
  localparam int HI_W   = MANT_W - WORD_W;
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][MANT_W-1:0] opnd_pk;
  logic                          unused_wr_hi;

  assign unused_wr_hi = ^wr_data[WORD_W-1:HI_W];

  // operand slot g owns select codes 2g (low word) and 2g+1 (high word)
  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    logic [WORD_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_sel == SEL_W'(2 * g))     lo_q <= wr_data;
        if (wr_sel == SEL_W'(2 * g + 1)) hi_q <= wr_data[HI_W-1:0];
      end
    end
    assign opnd_pk[g] = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          exp_word <= '0;
    else if (wr_en && wr_sel == SEL_EXP) exp_word <= wr_data;
  end

  assign dvd_mant = opnd_pk[0];
  assign dvs_mant = opnd_pk[1];
endmodule

// File: rtl/nrdiv_loop.sv
module nrdiv_loop #(
  parameter int MANT_W = 24,
  localparam int QBITS = MANT_W + 2,
  localparam int REM_W = MANT_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [MANT_W-1:0]       a_mant,
  input  logic [MANT_W-1:0]       b_mant,
  output logic [QBITS-1:0]        quo,
  output logic signed [REM_W-1:0] rem,
  output logic [MANT_W-1:0]       dvs,
  output logic                    active,
  output logic                    step_sub,
  output logic                    fin
);
  localparam int CNT_W = $clog2(QBITS);

  logic [CNT_W-1:0] cnt;
  logic [REM_W:0]   step;

  // One nonrestoring step: the sign of the partial remainder picks add or
  // subtract; the quotient bit is the sign of the result, inverted.
  // Returned as {qbit, new_remainder}.
  function automatic logic [REM_W:0] nr_step(input logic signed [REM_W-1:0] p,
                                             input logic [MANT_W-1:0] d);
    logic signed [REM_W-1:0] d_ext;
    logic signed [REM_W-1:0] t;
    d_ext = $signed({{(REM_W - MANT_W){1'b0}}, d});
    t     = p[REM_W-1] ? (p + d_ext) : (p - d_ext);
    return {~t[REM_W-1], t};
  endfunction

  assign step     = nr_step(rem, dvs);
  assign step_sub = active & ~rem[REM_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo    <= '0;
      rem    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem    <= $signed({{(REM_W - MANT_W){1'b0}}, a_mant});
        dvs    <= b_mant;
        quo    <= '0;
        cnt    <= '0;
        active <= 1'b1;
      end else if (active) begin
        quo <= {quo[QBITS-2:0], step[REM_W]};
        if (cnt == CNT_W'(QBITS - 1)) begin
          rem    <= step[REM_W-1:0];          // last step: keep unshifted
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          rem <= {step[REM_W-2:0], 1'b0};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nrdiv_post.sv
module nrdiv_post #(
  parameter int MANT_W = 24,
  parameter int WORD_W = 16,
  localparam int QBITS = MANT_W + 2,
  localparam int REM_W = MANT_W + 3
) (
  input  logic [QBITS-1:0]        quo,
  input  logic signed [REM_W-1:0] rem,
  input  logic [MANT_W-1:0]       dvs,
  input  logic [WORD_W-1:0]       exp_in,
  input  logic                    rtz,
  output logic signed [REM_W-1:0] rem_fixed,
  output logic                    ev_restore,
  output logic                    ev_norm,
  output logic                    ev_inc,
  output logic                    ev_carry,
  output logic [MANT_W-1:0]       mant_out,
  output logic [WORD_W-1:0]       exp_out
);
  logic [MANT_W-1:0] mant_t;
  logic              guard;
  logic              sticky;
  logic [MANT_W:0]   sum;

  function automatic logic round_up(input logic to_zero, input logic lsb,
                                    input logic g, input logic s);
    return !to_zero && g && (s || lsb);
  endfunction

  function automatic logic [WORD_W-1:0] exp_fix(input logic [WORD_W-1:0] e,
                                                input logic dec, input logic inc);
    return e + WORD_W'(inc) - WORD_W'(dec);
  endfunction

  // single restore after the loop
  assign ev_restore = rem[REM_W-1];
  assign rem_fixed  = ev_restore ? (rem + $signed({{(REM_W - MANT_W){1'b0}}, dvs})) : rem;

  // quotient below one needs a one-place left shift
  assign ev_norm = ~quo[QBITS-1];
  assign mant_t  = ev_norm ? quo[QBITS-2:1] : quo[QBITS-1:2];
  assign guard   = ev_norm ? quo[0] : quo[1];
  assign sticky  = (|rem_fixed) | (~ev_norm & quo[0]);

  assign ev_inc   = round_up(rtz, mant_t[0], guard, sticky);
  assign sum      = {1'b0, mant_t} + {{MANT_W{1'b0}}, ev_inc};
  assign ev_carry = sum[MANT_W];
  assign mant_out = ev_carry ? {1'b1, {(MANT_W - 1){1'b0}}} : sum[MANT_W-1:0];
  assign exp_out  = exp_fix(exp_in, ev_norm, ev_carry);
endmodule

// File: rtl/nrdiv_assist.sv
module nrdiv_assist
  import nrdiv_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [15:0]       wr_data,
  input  logic              start,
  input  logic              round_tz,
  output logic              busy,
  output logic              done,
  input  logic [1:0]        rd_sel,
  output logic [15:0]       rd_data
);
  localparam int QBITS = MANT_W + 2;
  localparam int REM_W = MANT_W + 3;
  localparam int HI_W  = MANT_W - WORD_W;

  ctl_state_e state;
  logic              start_ok;
  logic [MANT_W-1:0] dvd_mant, dvs_mant, dvs_run;
  logic [WORD_W-1:0] exp_word, exp_l;
  rnd_mode_e         rtz_l;
  logic [QBITS-1:0]  quo;
  logic signed [REM_W-1:0] rem, rem_fixed;
  logic              active, step_sub, fin;
  logic              ev_restore, ev_norm, ev_inc, ev_carry;
  logic [MANT_W-1:0] mant_out, res_mant;
  logic [WORD_W-1:0] exp_out, res_exp;

  assign start_ok = start && (state == CTL_IDLE);
  assign busy     = (state == CTL_RUN);

  nrdiv_regs #(.MANT_W(MANT_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dvd_mant(dvd_mant), .dvs_mant(dvs_mant), .exp_word(exp_word)
  );

  nrdiv_loop #(.MANT_W(MANT_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .a_mant(dvd_mant), .b_mant(dvs_mant),
    .quo(quo), .rem(rem), .dvs(dvs_run), .active(active), .step_sub(step_sub), .fin(fin)
  );

  nrdiv_post #(.MANT_W(MANT_W), .WORD_W(WORD_W)) u_post (
    .quo(quo), .rem(rem), .dvs(dvs_run), .exp_in(exp_l), .rtz(rtz_l == RND_TO_ZERO),
    .rem_fixed(rem_fixed), .ev_restore(ev_restore), .ev_norm(ev_norm), .ev_inc(ev_inc),
    .ev_carry(ev_carry), .mant_out(mant_out), .exp_out(exp_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CTL_IDLE;
      exp_l    <= '0;
      rtz_l    <= RND_NEAR_EVEN;
      res_mant <= '0;
      res_exp  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        state <= CTL_RUN;
        exp_l <= exp_word;
        rtz_l <= rnd_mode_e'(round_tz);
      end else if (fin) begin
        state    <= CTL_IDLE;
        res_mant <= mant_out;
        res_exp  <= exp_out;
        done     <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      RD_MANT_LO: rd_data = res_mant[WORD_W-1:0];
      RD_MANT_HI: rd_data = {{(WORD_W - HI_W){1'b0}}, res_mant[MANT_W-1:WORD_W]};
      RD_EXP:     rd_data = res_exp;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/nrdiv_assist_chk.sv
module nrdiv_assist_chk #(
  parameter int MANT_W = 24,
  parameter int WORD_W = 16,
  localparam int QBITS = MANT_W + 2,
  localparam int REM_W = MANT_W + 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    fin,
  input logic                    start_ok,
  input logic                    rtz_l,
  input logic                    ev_inc,
  input logic signed [REM_W-1:0] rem_fixed,
  input logic [MANT_W-1:0]       res_mant,
  input logic [WORD_W-1:0]       res_exp
);
  localparam int LAT_W = $clog2(QBITS + 4);
  logic [LAT_W-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_cnt <= '0;
    else if (start_ok) lat_cnt <= '0;
    else if (busy)     lat_cnt <= lat_cnt + 1'b1;
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r3:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_latency_r3:    assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_cnt == LAT_W'(QBITS + 1));
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  p_normal_r4:     assert property (@(posedge clk) disable iff (!rst_n) done |-> res_mant[MANT_W-1]);
  p_restored_r4:   assert property (@(posedge clk) disable iff (!rst_n) fin |-> !rem_fixed[REM_W-1]);
  p_no_inc_r7:     assert property (@(posedge clk) disable iff (!rst_n) (fin && rtz_l) |-> !ev_inc);
  p_hold_r9:       assert property (@(posedge clk) disable iff (!rst_n)
                                    !done |-> ($stable(res_mant) && $stable(res_exp)));
endmodule

bind nrdiv_assist nrdiv_assist_chk #(.MANT_W(MANT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fin(fin),
  .start_ok(start_ok), .rtz_l(rtz_l == nrdiv_pkg::RND_TO_ZERO), .ev_inc(ev_inc),
  .rem_fixed(rem_fixed), .res_mant(res_mant), .res_exp(res_exp)
);

// File: tb/test_nrdiv_assist.sv
module test_nrdiv_assist;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 27;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0, round_tz = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  wire         busy, done;
  wire  [15:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nrdiv_assist i_nrdiv_assist (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .round_tz(round_tz), .busy(busy), .done(done),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  typedef struct {
    logic [23:0] mant;
    logic [15:0] expo;
    int          start_cyc;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       last_item;
  int          checks = 0, fails = 0, cyc = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  always @(posedge clk) cyc++;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic item_t model(logic [23:0] a, logic [23:0] b, logic [15:0] e, bit rtz);
    item_t it;
    longint unsigned num, q, r;
    logic [23:0] m;
    logic [24:0] sum;
    bit g, s, inc;
    logic [15:0] ex;
    num = {40'd0, a} << 25;
    q   = num / {40'd0, b};
    r   = num % {40'd0, b};
    if (q[25]) begin m = q[25:2]; g = q[1]; s = q[0] || (r != 0); ex = e; end
    else       begin m = q[24:1]; g = q[0]; s = (r != 0);          ex = e - 16'd1; end
    inc = !rtz && g && (s || m[0]);
    sum = {1'b0, m} + {24'd0, inc};
    if (sum[24]) begin m = 24'h800000; ex = ex + 16'd1; end
    else m = sum[23:0];
    it.mant = m; it.expo = ex; it.start_cyc = 0;
    it.tag  = rtz ? "R4/R7" : "R4/R6";
    return it;
  endfunction

  task automatic wr(logic [2:0] sel, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic write_ops(logic [23:0] a, logic [23:0] b, logic [15:0] e);
    wr(3'd0, a[15:0]);
    wr(3'd1, {8'hA5, a[23:16]});   // junk in ignored upper bits (R2)
    wr(3'd2, b[15:0]);
    wr(3'd3, {8'h5A, b[23:16]});
    wr(3'd4, e);
  endtask

  task automatic pulse_start(bit rtz, output int sc);
    @(negedge clk);
    start = 1'b1; round_tz = rtz;
    @(posedge clk);
    #1 start = 1'b0;
    sc = cyc;
  endtask

  task automatic launch(logic [23:0] a, logic [23:0] b, logic [15:0] e, bit rtz);
    item_t it;
    int sc;
    write_ops(a, b, e);
    pulse_start(rtz, sc);
    it = model(a, b, e, rtz);
    it.start_cyc = sc;
    sb_q.push_back(it);
    #1 check("R3", "busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [23:0] rnd_mant();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return 24'h800000 | seed[22:0];
  endfunction

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) begin
          check("R3", "unexpected done", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          check("R3", "latency", cyc - it.start_cyc, LATENCY);
          check("R3", "busy low at done", {31'd0, busy}, 32'd0);
          rd_sel = 2'd0; #1 check(it.tag, "mant lo", {16'd0, rd_data}, {16'd0, it.mant[15:0]});
          rd_sel = 2'd1; #1 check("R2", "mant hi", {16'd0, rd_data}, {24'd0, it.mant[23:16]});
          rd_sel = 2'd2; #1 check("R5", "exponent", {16'd0, rd_data}, {16'd0, it.expo});
          last_item = it;
          @(negedge clk);
          check("R3", "done single cycle", {31'd0, done}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", {31'd0, busy}, 32'd0);
    check("R1", "done", {31'd0, done}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1 check("R1", "rd_data", {16'd0, rd_data}, 32'd0);
    end
    rst_n = 1'b1;

    // directed quotients (R4, R5, R6, R7)
    launch(24'h800000, 24'h800000, 16'd100, 1'b0); wait_idle();
    launch(24'hC00000, 24'h800000, 16'd100, 1'b0); wait_idle();
    launch(24'h800000, 24'hC00000, 16'd100, 1'b0); wait_idle();
    launch(24'h800000, 24'hC00000, 16'd100, 1'b1); wait_idle();
    launch(24'hFFFFFF, 24'h800000, 16'h7FFF, 1'b0); wait_idle();
    launch(24'h800000, 24'hFFFFFF, 16'd0, 1'b0); wait_idle();   // R5 wrap to FFFF
    launch(24'hFFFFFE, 24'hFFFFFF, 16'd3, 1'b0); wait_idle();
    launch(24'hFFFFFC, 24'hFFFFFF, 16'd3, 1'b1); wait_idle();
    launch(24'hABCDEF, 24'h9ABCDE, 16'h0180, 1'b0); wait_idle();
    launch(24'hABCDEF, 24'h9ABCDE, 16'h0180, 1'b1); wait_idle();

    // R2: codes 5..7 must not disturb stored operands
    write_ops(24'hD00001, 24'hA00003, 16'd42);
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'h1234); wr(3'd7, 16'h0000);
    begin
      item_t it;
      pulse_start(1'b0, sc);
      it = model(24'hD00001, 24'hA00003, 16'd42, 1'b0);
      it.start_cyc = sc; it.tag = "R2";
      sb_q.push_back(it);
    end
    wait_idle();

    // pseudo-random operands, both rounding modes
    for (int k = 0; k < 16; k++) begin
      launch(rnd_mant(), rnd_mant(), 16'(k * 37), k[0]);
      wait_idle();
    end

    // R8: second start and operand writes while busy
    launch(24'h912345, 24'hE54321, 16'd10, 1'b0);
    repeat (4) @(negedge clk);
    write_ops(24'hF00F00, 24'h811111, 16'd77);
    pulse_start(1'b1, sc);              // ignored, busy
    wait_idle();
    begin
      item_t it;
      pulse_start(1'b0, sc);            // uses operands written during run
      it = model(24'hF00F00, 24'h811111, 16'd77, 1'b0);
      it.start_cyc = sc; it.tag = "R8";
      sb_q.push_back(it);
    end
    wait_idle();

    // R9: writes without start leave results unchanged
    write_ops(24'h812345, 24'hFEDCBA, 16'd999);
    repeat (5) @(negedge clk);
    rd_sel = 2'd0; #1 check("R9", "hold mant lo", {16'd0, rd_data}, {16'd0, last_item.mant[15:0]});
    rd_sel = 2'd1; #1 check("R9", "hold mant hi", {16'd0, rd_data}, {24'd0, last_item.mant[23:16]});
    rd_sel = 2'd2; #1 check("R9", "hold exp", {16'd0, rd_data}, {16'd0, last_item.expo});
    rd_sel = 2'd3; #1 check("R2", "unused read code", {16'd0, rd_data}, 32'd0);
    check("R8", "no pending results", sb_q.size(), 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule